// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block holds the arithmetic reservation stations of an out-of-order floating-point core. It has two groups of stations: one serves add and subtract, the other serves multiply and divide. The issue stage presents at most one operation per cycle. Each source operand is either a ready value or the tag of the station or load buffer that will produce it. The block places the operation in the lowest-numbered free station of the matching group and returns that station's tag, or raises a stall when the group is full.

Waiting stations watch one shared result bus. When a station sees a tag it waits for, it copies the value and clears that tag. Once both operands are present, the station counts down a latency that depends on the operation. When the count ends, it computes an integer stand-in result and asks for the bus. A fixed-priority picker chooses one requesting station. An external arbiter decides which producer drives the bus in each cycle. A station is freed at the end of the cycle in which its own tag appears on the bus.

Top module: `resv_station_array`

## Requirements
- R1: After reset every station is free: `res_req` is 0, and with `iss_valid` low both `iss_stall` and `iss_tag` are 0.
- R2: Opcodes 0 (add) and 1 (sub) go to the lowest-index free station with tags 1 to N_ADD. Opcodes 2 (mul) and 3 (div) go to the lowest-index free station with tags N_ADD+1 to N_ADD+N_MUL. The tag chosen appears on `iss_tag` in the issue cycle. Tag 0 means "no producer", and tags above N_ADD+N_MUL belong to load buffers outside the block.
- R3: When the required group has no free station, `iss_stall` is 1, `iss_tag` is 0 and the operation is not taken. Such an operation never produces a result.
- R4: A source tag of 0 means the supplied value is used. A nonzero tag makes the station wait until that tag appears on the bus, then take the bus value. This includes a tag that is on the bus in the issue cycle itself.
- R5: With both operands ready at issue in cycle c, the station requests the bus in cycle c+L+1. L is 2 for add and sub, 10 for mul and 40 for div.
- R6: An operand taken from the bus in cycle b does not let the countdown start in cycle b. The request appears in cycle b+L+1.
- R7: Results are computed modulo 2^DATA_W. Add and sub wrap, mul keeps the low half of the product, and div is an unsigned quotient. Divide by zero yields all ones.
- R8: When several stations have results, the request goes to adders before multipliers and to the lowest index within a group. A station that is not served keeps requesting until its tag is on the bus.
- R9: A station whose tag is on the bus in cycle w is still occupied for issue in cycle w. It can be issued to from cycle w+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_op | input | 2 | Operation: 0 add, 1 sub, 2 mul, 3 div |
| iss_vj | input | DATA_W | First operand value |
| iss_qj | input | TAG_W | First operand producer tag, 0 if the value is ready |
| iss_vk | input | DATA_W | Second operand value |
| iss_qk | input | TAG_W | Second operand producer tag, 0 if the value is ready |
| iss_stall | output | 1 | Offered operation not taken: group full |
| iss_tag | output | TAG_W | Tag of the station taking the operation, 0 if none |
| bus_valid | input | 1 | Result bus carries a value this cycle |
| bus_tag | input | TAG_W | Producer tag on the result bus |
| bus_value | input | DATA_W | Value on the result bus |
| res_req | output | 1 | A station has a finished result |
| res_req_tag | output | TAG_W | Tag of the selected finished station |
| res_req_val | output | DATA_W | Result of the selected finished station |

## Verification
The bench uses the default parameters: three adder stations, two multiplier stations, 32-bit data, 3-bit tags, and latencies of 2, 10 and 40. These values let a full 40-cycle divide run, and they let the multiply group fill with only two operations. They also make it possible for an adder and a multiplier to finish in the same cycle, so priority and hold can be checked. Load-buffer tags 6 and 7 are driven onto the bus by the bench. This exercises wake-up of several waiting stations from one broadcast, capture in the issue cycle, and the one-cycle delay between capture and countdown.

// File: rtl/rsa_pkg.sv
// Shared types of the reservation station array.
// Assumes a 2-bit operation code is supplied by the issue stage.
package rsa_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } rsa_op_e;
endpackage

// File: rtl/rsa_alu.sv
// Integer stand-in for the arithmetic units: wrap-around add, sub and
// low-half multiply, and an unsigned divide that returns all ones for a
// zero divisor. Purely combinational.
module rsa_alu
    import rsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  rsa_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic [2*DATA_W-1:0] prod;

    // full-width product, low half used
    assign prod = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};

    // operation select
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[DATA_W-1:0];
            default: y = (b == '0) ? '1 : a / b;
        endcase
    end
endmodule

// File: rtl/rsa_pick.sv
// Fixed-priority finder: grants the lowest set bit of a request vector.
// Assumes nothing about the requests; the grant is one-hot or zero.
module rsa_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);
    // scan from index 0 upward, first hit wins
    always_comb begin
        gnt = '0;
        any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsa_entry.sv
// One reservation station. It takes an operation on alloc, snoops the
// result bus for its missing operands, and counts down the latency once
// both operands are present. It computes the result when the count reaches
// zero and frees itself when its own tag appears on the bus.
// Assumes alloc is only asserted while the station is free.
module rsa_entry
    import rsa_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 3,
    parameter int CNT_W   = 6,
    parameter int OWN_TAG = 1,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  rsa_op_e           al_op,
    input  logic [DATA_W-1:0] al_vj,
    input  logic [TAG_W-1:0]  al_qj,
    input  logic [DATA_W-1:0] al_vk,
    input  logic [TAG_W-1:0]  al_qk,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] res_o
);
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(OWN_TAG);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    logic              busy, done;
    rsa_op_e           op;
    logic [DATA_W-1:0] vj, vk, res, alu_y;
    logic [TAG_W-1:0]  qj, qk;
    logic [CNT_W-1:0]  cnt;
    logic              wr_hit, snoop_j, snoop_k, tick;
    logic              al_hit_j, al_hit_k;

    // latency chosen by operation
    function automatic logic [CNT_W-1:0] lat_of(rsa_op_e o);
        case (o)
            OP_MUL:  return CNT_W'(LAT_MUL);
            OP_DIV:  return CNT_W'(LAT_DIV);
            default: return CNT_W'(LAT_ADD);
        endcase
    endfunction

    rsa_alu #(.DATA_W(DATA_W)) u_alu (
        .op (op),
        .a  (vj),
        .b  (vk),
        .y  (alu_y)
    );

    // bus events seen by this station
    always_comb begin
        wr_hit   = busy && done && bus_valid && (bus_tag == MY_TAG);
        snoop_j  = busy && bus_valid && (qj != '0) && (bus_tag == qj);
        snoop_k  = busy && bus_valid && (qk != '0) && (bus_tag == qk);
        tick     = busy && (qj == '0) && (qk == '0) && (cnt != '0);
        al_hit_j = bus_valid && (al_qj != '0) && (bus_tag == al_qj);
        al_hit_k = bus_valid && (al_qk != '0) && (bus_tag == al_qk);
    end

    // station state: fill, free, capture and countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            op   <= OP_ADD;
            vj   <= '0;
            vk   <= '0;
            qj   <= '0;
            qk   <= '0;
            cnt  <= '0;
            res  <= '0;
        end else if (alloc) begin
            busy <= 1'b1;
            done <= 1'b0;
            op   <= al_op;
            cnt  <= lat_of(al_op);
            vj   <= al_hit_j ? bus_value : al_vj;
            qj   <= al_hit_j ? '0 : al_qj;
            vk   <= al_hit_k ? bus_value : al_vk;
            qk   <= al_hit_k ? '0 : al_qk;
        end else if (wr_hit) begin
            busy <= 1'b0;
            done <= 1'b0;
            vj   <= '0;
            vk   <= '0;
            qj   <= '0;
            qk   <= '0;
            cnt  <= '0;
        end else if (busy) begin
            if (snoop_j) begin
                vj <= bus_value;
                qj <= '0;
            end
            if (snoop_k) begin
                vk <= bus_value;
                qk <= '0;
            end
            if (tick) begin
                cnt <= cnt - ONE;
                if (cnt == ONE) begin
                    done <= 1'b1;
                    res  <= alu_y;
                end
            end
        end
    end

    assign busy_o = busy;
    assign done_o = done;
    assign res_o  = res;

    // R6: a capture from the bus freezes the count for that cycle
    p_hold_on_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_j || snoop_k) |=> (cnt == $past(cnt)));

    // R5: completion only with both operands present
    p_done_needs_ops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (qj == '0 && qk == '0));

    // R9: own tag on the bus frees the station at the edge
    p_free_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> !busy);
endmodule

// File: rtl/resv_station_array.sv
// Reservation station array: an adder group and a multiplier group.
// Issue takes the lowest free station of the group the operation needs.
// Finished stations are offered to the result bus through a fixed-priority
// picker (adders first, lowest index first).
// Assumes tags 1..N_ADD+N_MUL name stations, tag 0 means no producer, and
// higher tags are external load buffers; TAG_W must cover all of them.
module resv_station_array
    import rsa_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 3,
    parameter int N_ADD   = 3,
    parameter int N_MUL   = 2,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_qk,
    output logic              iss_stall,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_value,
    output logic              res_req,
    output logic [TAG_W-1:0]  res_req_tag,
    output logic [DATA_W-1:0] res_req_val
);
    localparam int N_ALL   = N_ADD + N_MUL;
    localparam int LAT_M1  = (LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD;
    localparam int LAT_MAX = (LAT_DIV > LAT_M1) ? LAT_DIV : LAT_M1;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    rsa_op_e           op_in;
    logic              to_mul, grp_any, add_any, mul_any;
    logic [N_ADD-1:0]  add_gnt;
    logic [N_MUL-1:0]  mul_gnt;
    logic [N_ALL-1:0]  busy_vec, done_vec, alloc_vec, bc_gnt;
    logic [DATA_W-1:0] res_arr [N_ALL];

    assign op_in  = rsa_op_e'(iss_op);
    assign to_mul = (op_in == OP_MUL) || (op_in == OP_DIV);

    rsa_pick #(.N(N_ADD)) u_pick_add (
        .req (~busy_vec[N_ADD-1:0]),
        .gnt (add_gnt),
        .any (add_any)
    );

    rsa_pick #(.N(N_MUL)) u_pick_mul (
        .req (~busy_vec[N_ALL-1:N_ADD]),
        .gnt (mul_gnt),
        .any (mul_any)
    );

    // issue steering and stall
    always_comb begin
        grp_any   = to_mul ? mul_any : add_any;
        iss_stall = iss_valid && !grp_any;
        alloc_vec = '0;
        if (iss_valid) begin
            if (to_mul) alloc_vec = {mul_gnt, {N_ADD{1'b0}}};
            else        alloc_vec = {{N_MUL{1'b0}}, add_gnt};
        end
    end

    // tag of the station receiving the operation
    always_comb begin
        iss_tag = '0;
        for (int i = 0; i < N_ALL; i++) begin
            if (alloc_vec[i]) iss_tag = TAG_W'(i + 1);
        end
    end

    generate
        for (genvar g = 0; g < N_ALL; g++) begin : g_st
            rsa_entry #(
                .DATA_W  (DATA_W),
                .TAG_W   (TAG_W),
                .CNT_W   (CNT_W),
                .OWN_TAG (g + 1),
                .LAT_ADD (LAT_ADD),
                .LAT_MUL (LAT_MUL),
                .LAT_DIV (LAT_DIV)
            ) u_st (
                .clk       (clk),
                .rst_n     (rst_n),
                .alloc     (alloc_vec[g]),
                .al_op     (op_in),
                .al_vj     (iss_vj),
                .al_qj     (iss_qj),
                .al_vk     (iss_vk),
                .al_qk     (iss_qk),
                .bus_valid (bus_valid),
                .bus_tag   (bus_tag),
                .bus_value (bus_value),
                .busy_o    (busy_vec[g]),
                .done_o    (done_vec[g]),
                .res_o     (res_arr[g])
            );
        end
    endgenerate

    rsa_pick #(.N(N_ALL)) u_pick_bc (
        .req (done_vec),
        .gnt (bc_gnt),
        .any (res_req)
    );

    // request tag and value of the winning station
    always_comb begin
        res_req_tag = '0;
        res_req_val = '0;
        for (int i = 0; i < N_ALL; i++) begin
            if (bc_gnt[i]) begin
                res_req_tag = TAG_W'(i + 1);
                res_req_val = res_arr[i];
            end
        end
    end

    // R2: at most one station is filled per cycle
    p_alloc_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec));

    // R3: a stall fills no station
    p_stall_no_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_stall |-> (alloc_vec == '0));

    // R8: an unserved request persists
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_req && !(bus_valid && bus_tag == res_req_tag)) |=> res_req);
endmodule

// File: tb/tb_resv_station_array.sv
`timescale 1ns/1ps
module tb_resv_station_array;
    localparam int DW = 32;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [1:0]    iss_op = '0;
    logic [DW-1:0] iss_vj = '0, iss_vk = '0;
    logic [TW-1:0] iss_qj = '0, iss_qk = '0;
    logic          iss_stall;
    logic [TW-1:0] iss_tag;
    logic          bus_valid;
    logic [TW-1:0] bus_tag;
    logic [DW-1:0] bus_value;
    logic          res_req;
    logic [TW-1:0] res_req_tag;
    logic [DW-1:0] res_req_val;
    logic          ld_v = 1'b0;
    logic [TW-1:0] ld_tag = '0;
    logic [DW-1:0] ld_val = '0;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    typedef struct {
        int          tag;
        logic [31:0] val;
        int          at;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // external arbiter: a load result wins over the stations
    assign bus_valid = ld_v | res_req;
    assign bus_tag   = ld_v ? ld_tag : res_req_tag;
    assign bus_value = ld_v ? ld_val : res_req_val;

    resv_station_array dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
        .iss_stall(iss_stall), .iss_tag(iss_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
        .res_req(res_req), .res_req_tag(res_req_tag), .res_req_val(res_req_val)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_res(input int tag, input logic [31:0] val,
                              input int at, input string req);
        exp_t e;
        e.tag = tag; e.val = val; e.at = at; e.req = req;
        sb.push_back(e);
    endtask

    // drive one issue cycle and check the tag and stall answer
    task automatic issue(input logic [1:0] op, input logic [31:0] vj,
                         input logic [2:0] qj, input logic [31:0] vk,
                         input logic [2:0] qk, input int want_tag,
                         input bit want_stall, input string req, output int at);
        iss_valid = 1'b1; iss_op = op;
        iss_vj = vj; iss_qj = qj; iss_vk = vk; iss_qk = qk;
        at = cyc;
        @(negedge clk);
        chk(iss_tag == TW'(want_tag), req, "iss_tag", 64'(iss_tag), 64'(want_tag));
        chk(iss_stall == want_stall, req, "iss_stall", 64'(iss_stall), 64'(want_stall));
        next_cycle();
        iss_valid = 1'b0;
    endtask

    task automatic ld_bcast(input logic [2:0] tag, input logic [31:0] val);
        ld_v = 1'b1; ld_tag = tag; ld_val = val;
        next_cycle();
        ld_v = 1'b0;
    endtask

    // monitor: match each station write against the scoreboard
    always @(negedge clk) begin : mon
        int k;
        if (rst_n && bus_valid && !ld_v) begin
            k = -1;
            foreach (sb[i]) if (k < 0 && sb[i].tag == int'(bus_tag)) k = i;
            if (k < 0) begin
                chk(1'b0, "R3", "unexpected result tag", 64'(bus_tag), 64'(0));
            end else begin
                chk(bus_value == sb[k].val, sb[k].req, "result value",
                    64'(bus_value), 64'(sb[k].val));
                chk(cyc == sb[k].at, sb[k].req, "result cycle",
                    64'(cyc), 64'(sb[k].at));
                sb.delete(k);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "R5", "watchdog expired", 64'(cyc), 64'(0));
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : stim
        int a, b, c;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(res_req == 1'b0, "R1", "res_req after reset", 64'(res_req), 64'(0));
        chk(iss_stall == 1'b0, "R1", "iss_stall idle", 64'(iss_stall), 64'(0));
        chk(iss_tag == '0, "R1", "iss_tag idle", 64'(iss_tag), 64'(0));
        next_cycle();

        // R2 R5: ready add into adder 1
        issue(2'd0, 32'd5, 3'd0, 32'd7, 3'd0, 1, 1'b0, "R2", a);
        expect_res(1, 32'd12, a + 3, "R5");
        repeat (6) next_cycle();

        // R7 R5 R3: sub wrap, mul, div, then multiplier group full
        issue(2'd1, 32'd3, 3'd0, 32'd5, 3'd0, 1, 1'b0, "R2", a);
        expect_res(1, 32'hFFFF_FFFE, a + 3, "R7");
        issue(2'd2, 32'd6, 3'd0, 32'd7, 3'd0, 4, 1'b0, "R2", b);
        expect_res(4, 32'd42, b + 11, "R5");
        issue(2'd3, 32'd100, 3'd0, 32'd7, 3'd0, 5, 1'b0, "R2", c);
        expect_res(5, 32'd14, c + 41, "R5");
        issue(2'd2, 32'd9, 3'd0, 32'd9, 3'd0, 0, 1'b1, "R3", a);
        repeat (45) next_cycle();

        // R7: divide by zero, full 40-cycle latency
        issue(2'd3, 32'd9, 3'd0, 32'd0, 3'd0, 4, 1'b0, "R7", a);
        expect_res(4, 32'hFFFF_FFFF, a + 41, "R7");
        repeat (45) next_cycle();

        // R4 R6: sub waits on adder 1
        issue(2'd0, 32'd1, 3'd0, 32'd2, 3'd0, 1, 1'b0, "R4", a);
        expect_res(1, 32'd3, a + 3, "R4");
        issue(2'd1, 32'd0, 3'd1, 32'd1, 3'd0, 2, 1'b0, "R4", b);
        expect_res(2, 32'd2, a + 6, "R6");
        repeat (8) next_cycle();

        // R6 R8: one load broadcast wakes two adders
        issue(2'd0, 32'd0, 3'd6, 32'd10, 3'd0, 1, 1'b0, "R4", a);
        issue(2'd0, 32'd4, 3'd0, 32'd0, 3'd6, 2, 1'b0, "R4", b);
        c = cyc;
        ld_bcast(3'd6, 32'd20);
        expect_res(1, 32'd30, c + 3, "R6");
        expect_res(2, 32'd24, c + 4, "R8");
        repeat (6) next_cycle();

        // R4: tag on the bus in the issue cycle itself
        ld_v = 1'b1; ld_tag = 3'd7; ld_val = 32'd50;
        issue(2'd0, 32'd0, 3'd7, 32'd1, 3'd0, 1, 1'b0, "R4", a);
        ld_v = 1'b0;
        expect_res(1, 32'd51, a + 3, "R4");
        repeat (6) next_cycle();

        // R8: adder and multiplier finish together, adder first
        issue(2'd2, 32'd2, 3'd0, 32'd3, 3'd0, 4, 1'b0, "R2", a);
        repeat (7) next_cycle();
        issue(2'd0, 32'd1, 3'd0, 32'd1, 3'd0, 1, 1'b0, "R2", b);
        expect_res(1, 32'd2, a + 11, "R8");
        expect_res(4, 32'd6, a + 12, "R8");
        repeat (8) next_cycle();

        // R9: station written this cycle is not refilled until next cycle
        issue(2'd0, 32'd1, 3'd0, 32'd1, 3'd0, 1, 1'b0, "R2", a);
        expect_res(1, 32'd2, a + 3, "R9");
        issue(2'd0, 32'd2, 3'd0, 32'd2, 3'd0, 2, 1'b0, "R2", b);
        expect_res(2, 32'd4, a + 4, "R9");
        issue(2'd0, 32'd3, 3'd0, 32'd3, 3'd0, 3, 1'b0, "R2", b);
        expect_res(3, 32'd6, a + 5, "R9");
        issue(2'd1, 32'd8, 3'd0, 32'd1, 3'd0, 0, 1'b1, "R9", b);
        issue(2'd0, 32'd10, 3'd0, 32'd10, 3'd0, 1, 1'b0, "R9", c);
        expect_res(1, 32'd20, c + 3, "R9");
        repeat (10) next_cycle();

        chk(sb.size() == 0, "R5", "results outstanding", 64'(sb.size()), 64'(0));
        chk(res_req == 1'b0, "R9", "idle after drain", 64'(res_req), 64'(0));
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule